// File: doc/BRIEF.md
# Constant/Live Register Space Front End

This block sits between a device's management transport and its registers. It accepts single-word read and write requests, each carrying a 32-bit byte address, through a valid/ready request port. It answers each request with a one-cycle response pulse that carries read data and an error flag. The address space is split at a power-of-two boundary set by `STATIC_BITS`. Every address whose bits above that boundary are all zero is constant space. Constant space is served from a ROM built from parameters. Every other address is live space, and live accesses are handed to an external handler.

The constant ROM begins at address 0. Word 0 is the identification word: the identifier 0xE71D in the upper half and a capability bitmap in the lower half. Words 0x04, 0x08 and 0x0C are reserved constants. A feature declaration list is stored from 0x10 upward. Writes into constant space are accepted and then dropped. Live addresses may stand for actions rather than storage. For this reason the block holds a live request on its handler port until the handler signals done, and keeps only one request outstanding at a time.

Top module: `regspace_front`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `hnd_valid` are 0.
- R2: A read of address 0x0 returns 0xE71D in bits [31:16]. `rsp_valid` is high in the cycle right after the accepting clock edge.
- R3: In word 0, bit 15 (list present) reads 1 and bits 14:12 (reserved) read 0, whatever `CAPS` holds. Bits 11:0 equal `CAPS[11:0]`, and bit 0 flags multicast discovery support.
- R4: Reads of 0x04, 0x08 and 0x0C return 0x00000000.
- R5: Word i of `FEAT_LIST` (bits 32i+31:32i) is returned at address 0x10 + 4i.
- R6: A read of a constant address beyond the last populated ROM word returns 0x00000000.
- R7: A write to a constant address responds next cycle with `rsp_err` 0 and raises no handler request. A later read of that address still returns the ROM value.
- R8: An aligned request with any of bits [31:STATIC_BITS] set drives `hnd_valid`. While `hnd_valid` is high, `hnd_write`, `hnd_addr` and `hnd_wdata` hold the request's values until `hnd_done` is seen.
- R9: The clock edge that samples `hnd_done` ends the handler request. The response appears in the next cycle with `rsp_err` 0, and it carries `hnd_rdata` for a read or 0 for a write.
- R10: A request with addr[1:0] != 0 responds next cycle with `rsp_err` 1 and `rsp_rdata` 0, and performs no access.
- R11: `req_ready` is 0 while a handler request is pending, so only one live access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Misaligned request |
| rsp_rdata | output | 32 | Read data |
| hnd_valid | output | 1 | Live access pending at handler |
| hnd_write | output | 1 | Handler access is a write |
| hnd_addr | output | 32 | Handler byte address |
| hnd_wdata | output | 32 | Handler write data |
| hnd_done | input | 1 | Handler completes the access |
| hnd_rdata | input | 32 | Handler read data |

## Verification
A wrong region decode shows up at the ports on the next cycle. A constant address that is misrouted raises `hnd_valid` and drops `req_ready`. A live address that is misrouted returns a response at once with no handler request. A corrupt busy flag shows as `req_ready` staying low after the done strobe, or as a response pulse before the done strobe, and either appears within one cycle. A stale handler capture shows as changed `hnd_addr` or `hnd_wdata` during the wait. A ROM index error shows as a wrong word on the first read of an affected address.

// File: rtl/regspace_front.sv
module regspace_front #(
  parameter int          STATIC_BITS = 8,
  parameter logic [15:0] CAPS        = 16'h7001,
  parameter int          FEAT_WORDS  = 3,
  parameter logic [32*FEAT_WORDS-1:0] FEAT_LIST =
    {32'hFFF0_0000, 32'h0000_0100, 32'h0010_0101}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        hnd_valid,
  output logic        hnd_write,
  output logic [31:0] hnd_addr,
  output logic [31:0] hnd_wdata,
  input  logic        hnd_done,
  input  logic [31:0] hnd_rdata
);
  localparam int          WIDX     = STATIC_BITS - 2;
  localparam int          LIST_IDX = 4;
  localparam logic [15:0] ID_WORD  = 16'hE71D;
  localparam logic [15:0] CAP_WORD = {1'b1, 3'b000, CAPS[11:0]};

  logic            busy;
  logic            accept, misaligned, is_static;
  logic [WIDX-1:0] widx;
  logic [31:0]     rom_word;

  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign misaligned = req_addr[1:0] != 2'b00;
  assign is_static  = req_addr[31:STATIC_BITS] == '0;
  assign widx       = req_addr[STATIC_BITS-1:2];
  assign hnd_valid  = busy;

  always_comb begin
    rom_word = 32'h0;
    if (widx == '0) rom_word = {ID_WORD, CAP_WORD};
    for (int i = 0; i < FEAT_WORDS; i++)
      if (32'(widx) == i + LIST_IDX) rom_word = FEAT_LIST[i*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'h0;
      hnd_write <= 1'b0;
      hnd_addr  <= 32'h0;
      hnd_wdata <= 32'h0;
    end else begin
      rsp_valid <= 1'b0;
      if (busy) begin
        if (hnd_done) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= hnd_write ? 32'h0 : hnd_rdata;
        end
      end else if (accept) begin
        if (misaligned) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_rdata <= 32'h0;
        end else if (is_static) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= req_write ? 32'h0 : rom_word;
        end else begin
          busy      <= 1'b1;
          hnd_write <= req_write;
          hnd_addr  <= req_addr;
          hnd_wdata <= req_wdata;
        end
      end
    end
  end
endmodule

module regspace_front_chk #(
  parameter int STATIC_BITS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        hnd_valid,
  input logic        hnd_write,
  input logic [31:0] hnd_addr,
  input logic [31:0] hnd_wdata,
  input logic        hnd_done
);
  logic acc, acc_static, acc_mis;
  assign acc        = req_valid && req_ready;
  assign acc_mis    = acc && req_addr[1:0] != 2'b00;
  assign acc_static = acc && req_addr[1:0] == 2'b00 && req_addr[31:STATIC_BITS] == '0;

  p_static_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_static |=> rsp_valid && !rsp_err);
  p_static_no_hnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_static |=> !hnd_valid);
  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid && !hnd_done |=> hnd_valid && $stable(hnd_addr) && $stable(hnd_wdata) && $stable(hnd_write));
  p_done_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid && hnd_done |=> rsp_valid && !rsp_err && !hnd_valid);
  p_write_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid && hnd_done && hnd_write |=> rsp_rdata == 32'h0);
  p_misalign_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mis |=> rsp_valid && rsp_err && !hnd_valid && rsp_rdata == 32'h0);
  p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid |-> !req_ready);
  p_no_rsp_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid && !hnd_done |=> !rsp_valid);
endmodule

bind regspace_front regspace_front_chk #(.STATIC_BITS(STATIC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .hnd_valid(hnd_valid),
  .hnd_write(hnd_write), .hnd_addr(hnd_addr), .hnd_wdata(hnd_wdata),
  .hnd_done(hnd_done)
);

// File: tb/tb_regspace_front.sv
module tb_regspace_front;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, hnd_done = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, hnd_rdata = '0;
  logic        req_ready, rsp_valid, rsp_err, hnd_valid, hnd_write;
  logic [31:0] rsp_rdata, hnd_addr, hnd_wdata;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regspace_front dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .hnd_valid(hnd_valid), .hnd_write(hnd_write), .hnd_addr(hnd_addr),
    .hnd_wdata(hnd_wdata), .hnd_done(hnd_done), .hnd_rdata(hnd_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 hnd_valid", 32'(hnd_valid), 0);
  endtask

  task automatic t_sread(input logic [31:0] a, input logic [31:0] exp, input string tag);
    issue(1'b0, a, 32'h0);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 1);
    chk({tag, " rsp_err"}, 32'(rsp_err), 0);
    chk({tag, " data"}, rsp_rdata, exp);
    chk({tag, " no handler"}, 32'(hnd_valid), 0);
  endtask

  task automatic t_swrite;
    issue(1'b1, 32'h0000_0010, 32'hDEAD_BEEF);
    chk("R7 rsp_valid", 32'(rsp_valid), 1);
    chk("R7 rsp_err", 32'(rsp_err), 0);
    chk("R7 no handler", 32'(hnd_valid), 0);
    chk("R7 ready", 32'(req_ready), 1);
    t_sread(32'h0000_0010, 32'h0010_0101, "R7 readback");
  endtask

  task automatic t_dyn(input logic wr, input logic [31:0] a, input logic [31:0] d,
                       input logic [31:0] rd, input int waits);
    issue(wr, a, d);
    chk("R8 hnd_valid", 32'(hnd_valid), 1);
    chk("R11 not ready", 32'(req_ready), 0);
    chk("R8 no early rsp", 32'(rsp_valid), 0);
    for (int i = 0; i < waits; i++) begin
      @(posedge clk); #1;
      chk("R8 hold valid", 32'(hnd_valid), 1);
      chk("R8 addr", hnd_addr, a);
      chk("R8 write", 32'(hnd_write), 32'(wr));
      chk("R8 wdata", hnd_wdata, d);
      chk("R11 no rsp while waiting", 32'(rsp_valid), 0);
    end
    @(negedge clk);
    hnd_done = 1'b1; hnd_rdata = rd;
    @(posedge clk); #1;
    hnd_done = 1'b0; hnd_rdata = 32'h0;
    chk("R9 rsp_valid", 32'(rsp_valid), 1);
    chk("R9 rsp_err", 32'(rsp_err), 0);
    chk("R9 data", rsp_rdata, wr ? 32'h0 : rd);
    chk("R9 handler released", 32'(hnd_valid), 0);
    chk("R11 ready again", 32'(req_ready), 1);
    @(posedge clk); #1;
    chk("R9 single pulse", 32'(rsp_valid), 0);
  endtask

  task automatic t_misalign(input logic [31:0] a);
    issue(1'b0, a, 32'h0);
    chk("R10 rsp_valid", 32'(rsp_valid), 1);
    chk("R10 rsp_err", 32'(rsp_err), 1);
    chk("R10 data", rsp_rdata, 32'h0);
    chk("R10 no handler", 32'(hnd_valid), 0);
    chk("R10 ready", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    issue(1'b0, 32'h0, 32'h0);
    chk("R2 rsp_valid", 32'(rsp_valid), 1);
    chk("R2 id", 32'(rsp_rdata[31:16]), 32'hE71D);
    chk("R3 caps", 32'(rsp_rdata[15:0]), 32'h8001);
    t_sread(32'h0000_0004, 32'h0, "R4 word1");
    t_sread(32'h0000_0008, 32'h0, "R4 word2");
    t_sread(32'h0000_000C, 32'h0, "R4 word3");
    t_sread(32'h0000_0010, 32'h0010_0101, "R5 list0");
    t_sread(32'h0000_0014, 32'h0000_0100, "R5 list1");
    t_sread(32'h0000_0018, 32'hFFF0_0000, "R5 list2");
    t_sread(32'h0000_001C, 32'h0, "R6 past list");
    t_sread(32'h0000_00FC, 32'h0, "R6 top static");
    t_swrite();
    t_dyn(1'b0, 32'h0000_0100, 32'h0, 32'h1234_5678, 3);
    t_dyn(1'b1, 32'h8000_0040, 32'hA5A5_0F0F, 32'hFFFF_FFFF, 2);
    t_dyn(1'b0, 32'h0001_0000, 32'h0, 32'hCAFE_F00D, 0);
    t_misalign(32'h0000_0002);
    t_misalign(32'h0000_0101);
    t_sread(32'h0000_0000, {16'hE71D, 16'h8001}, "R2 again");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule